// File: doc/BRIEF.md
# Speculative Register Reclamation Queue

While a core runs ahead speculatively, the instructions it renames are executed and then thrown away, so they never commit and can never release their registers through the normal commit path. This queue gives those registers back. Each time a speculative instruction is renamed, the queue records, in program order at its tail, the instruction's ID and the physical register previously mapped to its destination. Completions arrive in any order and set each entry's executed flag. Entries leave from the head strictly in program order, and only once executed. Each departure hands its recorded register to the speculative free list. An in-order release guarantees that no older in-flight instruction can still read the freed register.

The queue works only while `spec_mode` is high. Dropping `spec_mode` empties it at once and releases nothing. Registers handed out during speculation come only from the pool that was free at mode entry, so the normal-mode free list is never touched. Up to four instructions allocate per cycle. The allocator learns the slot of each instruction from `alloc_base`, and a completion names both that slot and the instruction ID. Up to four entries retire per cycle.

Top module: `spec_reclaim_q`

## Requirements
- R1: After reset, and in any cycle after a cycle with `spec_mode` low, the queue is empty: `alloc_ready` is 1, `alloc_base` is 0 and `free_valid` is 0.
- R2: In an accepted cycle, the set lanes of `alloc_valid` take consecutive slots in ascending lane order. The first takes slot `alloc_base`, and `alloc_base` then advances by the number of set lanes.
- R3: A completion on lane d marks slot `done_idx[d]` executed only if that slot holds a live entry whose stored ID equals `done_id[d]`. Any other completion has no effect.
- R4: Entries retire only from the head, in program order. An unexecuted head entry blocks every younger entry, even executed ones.
- R5: Up to four entries retire per cycle. Free lane k carries the entry k places behind the head. A retirement is visible on `free_valid`/`free_tag` in the cycle after the completion edge that made it eligible, and it takes effect at the next edge.
- R6: An entry allocated with `alloc_has_dst` low retires in its turn but raises no `free_valid` bit on its lane.
- R7: `alloc_ready` is low exactly when fewer than four slots are free, counting the 192 slots. While it is low, all allocation lanes are ignored and `alloc_base` holds.
- R8: A cycle with `spec_mode` low discards every entry without releasing any register. Completions naming discarded entries are then ignored.
- R9: Slot numbers wrap from 191 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spec_mode | input | 1 | High while speculating; low clears the queue |
| alloc_valid | input | 4 | Per-lane allocate request |
| alloc_has_dst | input | 4 | Lane has a destination register to reclaim |
| alloc_id | input | 48 | Per-lane 12-bit instruction ID, lane 0 in the low bits |
| alloc_old_tag | input | 32 | Per-lane 8-bit previous physical register |
| alloc_ready | output | 1 | At least four free slots |
| alloc_base | output | 8 | Slot taken by the first set allocation lane |
| done_valid | input | 4 | Per-lane completion mark |
| done_idx | input | 32 | Per-lane 8-bit slot number |
| done_id | input | 48 | Per-lane 12-bit instruction ID |
| free_valid | output | 4 | Per-lane register release |
| free_tag | output | 32 | Per-lane 8-bit released register |

## Verification
Allocation and completion both act at the clock edge that samples them. A completion that makes entries eligible therefore shows on the free outputs within that same cycle, after the edge, and those entries leave the queue at the following edge. `alloc_base` reflects each allocation one edge after it is driven. The bench drives inputs just after a rising edge and samples at the falling edge. Each release is checked on the falling edge directly after the completion that unlocks it, and blocked or ignored cases are checked over the following cycles. A scoreboard of expected released tags in program order is compared lane by lane against every observed release.

// File: rtl/spec_reclaim_q.sv
module spec_reclaim_q #(
  parameter int DEPTH   = 192,
  parameter int TAG_W   = 8,
  parameter int ID_W    = 12,
  parameter int ALLOC_N = 4,
  parameter int DONE_N  = 4,
  parameter int FREE_N  = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spec_mode,
  input  logic [ALLOC_N-1:0]      alloc_valid,
  input  logic [ALLOC_N-1:0]      alloc_has_dst,
  input  logic [ALLOC_N*ID_W-1:0] alloc_id,
  input  logic [ALLOC_N*TAG_W-1:0] alloc_old_tag,
  output logic                    alloc_ready,
  output logic [IDX_W-1:0]        alloc_base,
  input  logic [DONE_N-1:0]       done_valid,
  input  logic [DONE_N*IDX_W-1:0] done_idx,
  input  logic [DONE_N*ID_W-1:0]  done_id,
  output logic [FREE_N-1:0]       free_valid,
  output logic [FREE_N*TAG_W-1:0] free_tag
);

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a, input int b);
    int s;
    s = int'(a) + b;
    return IDX_W'(s >= DEPTH ? s - DEPTH : s);
  endfunction

  logic [DEPTH-1:0] live_q, exec_q, dst_q;
  logic [ID_W-1:0]  id_q  [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  logic [FREE_N-1:0]  ret;
  logic [IDX_W-1:0]   ret_idx [FREE_N];
  logic [ALLOC_N-1:0] a_go;
  logic [IDX_W-1:0]   a_idx [ALLOC_N];
  logic [DONE_N-1:0]  d_hit;
  int n_ret, n_alloc;

  assign alloc_ready = (32'(count_q) + ALLOC_N) <= DEPTH;
  assign alloc_base  = tail_q;

  for (genvar k = 0; k < FREE_N; k++) begin : g_free
    assign ret_idx[k] = wrap_add(head_q, k);
    assign free_valid[k] = ret[k] & dst_q[ret_idx[k]];
    assign free_tag[k*TAG_W +: TAG_W] = tag_q[ret_idx[k]];
  end

  for (genvar d = 0; d < DONE_N; d++) begin : g_done
    logic [IDX_W-1:0] di;
    assign di = done_idx[d*IDX_W +: IDX_W];
    assign d_hit[d] = done_valid[d] && (32'(di) < DEPTH) && live_q[di] &&
                      (id_q[di] == done_id[d*ID_W +: ID_W]);
  end

  always_comb begin
    logic run;
    run = spec_mode;
    n_ret = 0;
    for (int k = 0; k < FREE_N; k++) begin
      run = run & live_q[ret_idx[k]] & exec_q[ret_idx[k]];
      ret[k] = run;
      n_ret = n_ret + int'(run);
    end
  end

  always_comb begin
    n_alloc = 0;
    for (int i = 0; i < ALLOC_N; i++) begin
      a_go[i]  = spec_mode & alloc_ready & alloc_valid[i];
      a_idx[i] = wrap_add(tail_q, n_alloc);
      n_alloc  = n_alloc + int'(a_go[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0; exec_q <= '0; dst_q <= '0;
      head_q <= '0; tail_q <= '0; count_q <= '0;
    end else if (!spec_mode) begin
      live_q <= '0; exec_q <= '0;
      head_q <= '0; tail_q <= '0; count_q <= '0;
    end else begin
      for (int k = 0; k < FREE_N; k++)
        if (ret[k]) live_q[ret_idx[k]] <= 1'b0;
      for (int d = 0; d < DONE_N; d++)
        if (d_hit[d]) exec_q[done_idx[d*IDX_W +: IDX_W]] <= 1'b1;
      for (int i = 0; i < ALLOC_N; i++)
        if (a_go[i]) begin
          live_q[a_idx[i]] <= 1'b1;
          exec_q[a_idx[i]] <= 1'b0;
          dst_q[a_idx[i]]  <= alloc_has_dst[i];
        end
      head_q  <= wrap_add(head_q, n_ret);
      tail_q  <= wrap_add(tail_q, n_alloc);
      count_q <= CNT_W'(32'(count_q) + n_alloc - n_ret);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ALLOC_N; i++)
      if (a_go[i]) begin
        id_q[a_idx[i]]  <= alloc_id[i*ID_W +: ID_W];
        tag_q[a_idx[i]] <= alloc_old_tag[i*TAG_W +: TAG_W];
      end
  end

endmodule

// File: rtl/reclaim_q_chk.sv
module reclaim_q_chk #(
  parameter int DEPTH   = 192,
  parameter int ALLOC_N = 4,
  parameter int FREE_N  = 4,
  parameter int CNT_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spec_mode,
  input logic              alloc_ready,
  input logic [FREE_N-1:0] free_valid,
  input logic [CNT_W-1:0]  count
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_mode && !alloc_ready) |=> (count <= $past(count))); // R7

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_mode |=> (count == '0)); // R8

  AST_REENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spec_mode) |-> (free_valid == '0)); // R8

  AST_RETIRE_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    spec_mode |=> (32'(count) + FREE_N >= 32'($past(count)))); // R5

endmodule

bind spec_reclaim_q reclaim_q_chk #(
  .DEPTH(DEPTH), .ALLOC_N(ALLOC_N), .FREE_N(FREE_N), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode), .alloc_ready(alloc_ready),
  .free_valid(free_valid), .count(count_q)
);

// File: tb/tb_spec_reclaim_q.sv
`timescale 1ns/1ps
module tb_spec_reclaim_q;
  localparam int DEPTH = 192;

  logic clk = 0, rst_n = 0, spec_mode = 0;
  logic [3:0] alloc_valid = '0, alloc_has_dst = '0;
  logic [47:0] alloc_id = '0;
  logic [31:0] alloc_old_tag = '0;
  logic alloc_ready;
  logic [7:0] alloc_base;
  logic [3:0] done_valid = '0;
  logic [31:0] done_idx = '0;
  logic [47:0] done_id = '0;
  logic [3:0] free_valid;
  logic [31:0] free_tag;

  spec_reclaim_q dut (.*);

  always #4 clk = ~clk;

  int errs = 0, checks = 0;
  logic [7:0] exp_q[$];
  int id_at[DEPTH];
  int lane_idx[4], lane_id[4];
  int mtail = 0, next_id = 100, next_tag = 10;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    for (int k = 0; k < 4; k++) if (free_valid[k]) begin
      if (exp_q.size() == 0) chk(0, "R5", "unexpected release tag", int'(free_tag[k*8 +: 8]), -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(free_tag[k*8 +: 8] == e, "R5", "released tag in order", int'(free_tag[k*8 +: 8]), int'(e));
      end
    end
  end

  task automatic do_alloc(input logic [3:0] v, input logic [3:0] h, input bit accept);
    for (int i = 0; i < 4; i++) begin
      alloc_valid[i] = v[i];
      alloc_has_dst[i] = h[i];
      alloc_id[i*12 +: 12] = 12'(next_id);
      alloc_old_tag[i*8 +: 8] = 8'(next_tag);
      lane_id[i] = next_id;
      if (v[i] && accept) begin
        id_at[mtail] = next_id;
        lane_idx[i] = mtail;
        if (h[i]) exp_q.push_back(8'(next_tag));
        mtail = (mtail + 1) % DEPTH;
      end
      next_id++;
      next_tag++;
    end
    @(posedge clk); #1;
    alloc_valid = '0;
  endtask

  task automatic mark(input logic [3:0] lanes, input int i0, input int i1, input int i2, input int i3,
                      input int d0, input int d1, input int d2, input int d3);
    done_valid = lanes;
    done_idx = {8'(i3), 8'(i2), 8'(i1), 8'(i0)};
    done_id = {12'(d3), 12'(d2), 12'(d1), 12'(d0)};
    @(posedge clk); #1;
    done_valid = '0;
  endtask

  task automatic expect_free(input logic [3:0] e, input string req);
    @(negedge clk);
    chk(free_valid == e, req, "free_valid", int'(free_valid), int'(e));
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(alloc_ready == 1, "R1", "ready after reset", int'(alloc_ready), 1);
    chk(alloc_base == 0, "R1", "base after reset", int'(alloc_base), 0);
    chk(free_valid == 0, "R1", "no release after reset", int'(free_valid), 0);
    @(posedge clk); #1 spec_mode = 1;

    // R2 R4 R5 R6: eight entries, one without destination
    do_alloc(4'b1111, 4'b1111, 1);
    do_alloc(4'b1111, 4'b1011, 1);
    @(negedge clk);
    chk(alloc_base == 8, "R2", "base after eight", int'(alloc_base), 8);
    @(posedge clk); #1;
    mark(4'b1111, 4, 7, 5, 6, id_at[4], id_at[7], id_at[5], id_at[6]);
    mark(4'b0111, 1, 3, 2, 0, id_at[1], id_at[3], id_at[2], 0);
    repeat (3) expect_free(4'b0000, "R4");
    @(posedge clk); #1;
    mark(4'b0001, 0, 0, 0, 0, id_at[0], 0, 0, 0);
    expect_free(4'b1111, "R5");
    expect_free(4'b1011, "R6");
    expect_free(4'b0000, "R5");

    // R3: wrong id ignored
    @(posedge clk); #1;
    do_alloc(4'b0001, 4'b0001, 1);
    mark(4'b0001, lane_idx[0], 0, 0, 0, id_at[lane_idx[0]] + 1, 0, 0, 0);
    repeat (2) expect_free(4'b0000, "R3");
    @(posedge clk); #1;
    mark(4'b0001, lane_idx[0], 0, 0, 0, id_at[lane_idx[0]], 0, 0, 0);
    expect_free(4'b0001, "R3");

    // R2 sparse lanes, R4 head blocks
    @(posedge clk); #1;
    b = mtail;
    do_alloc(4'b0101, 4'b0101, 1);
    @(negedge clk);
    chk(int'(alloc_base) == (b + 2) % DEPTH, "R2", "base after sparse", int'(alloc_base), (b + 2) % DEPTH);
    @(posedge clk); #1;
    mark(4'b0001, lane_idx[2], 0, 0, 0, id_at[lane_idx[2]], 0, 0, 0);
    repeat (2) expect_free(4'b0000, "R4");
    @(posedge clk); #1;
    mark(4'b0001, lane_idx[0], 0, 0, 0, id_at[lane_idx[0]], 0, 0, 0);
    expect_free(4'b0011, "R2");

    // R9: wrap
    for (int it = 0; it < 50; it++) begin
      @(posedge clk); #1;
      do_alloc(4'b1111, 4'b1111, 1);
      mark(4'b1111, lane_idx[0], lane_idx[1], lane_idx[2], lane_idx[3],
           id_at[lane_idx[0]], id_at[lane_idx[1]], id_at[lane_idx[2]], id_at[lane_idx[3]]);
      @(negedge clk);
      chk(int'(alloc_base) == mtail, "R9", "base across wrap", int'(alloc_base), mtail);
      @(posedge clk);
    end
    @(negedge clk);
    chk(exp_q.size() == 0, "R9", "all wrapped entries released", exp_q.size(), 0);

    // R8: clear discards and ignores late marks
    @(posedge clk); #1;
    do_alloc(4'b0011, 4'b0011, 1);
    spec_mode = 0;
    @(posedge clk); #1;
    spec_mode = 1;
    exp_q.delete();
    @(negedge clk);
    chk(alloc_base == 0, "R1", "base after clear", int'(alloc_base), 0);
    chk(free_valid == 0, "R8", "nothing freed on clear", int'(free_valid), 0);
    @(posedge clk); #1;
    mark(4'b0011, lane_idx[0], lane_idx[1], 0, 0, id_at[lane_idx[0]], id_at[lane_idx[1]], 0, 0);
    repeat (2) expect_free(4'b0000, "R8");
    mtail = 0;

    // R7: fill
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      chk(alloc_ready == 1, "R7", "ready while room", int'(alloc_ready), 1);
      @(posedge clk); #1;
      do_alloc(4'b1111, 4'b0000, 1);
    end
    @(negedge clk);
    chk(alloc_ready == 0, "R7", "not ready when full", int'(alloc_ready), 0);
    @(posedge clk); #1;
    do_alloc(4'b1111, 4'b1111, 0);
    @(negedge clk);
    chk(alloc_base == 0, "R7", "base holds while full", int'(alloc_base), 0);
    chk(exp_q.size() == 0, "R7", "no stray releases", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule